// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A presettable binary counter of parameterised width (four bits by default) that steps up or down, wrapping at its natural modulus. Every register bit updates together on the rising clock edge, so the count outputs never ripple. A synchronous active-high reset clears the count, and an active-low load strobe copies the data inputs into the counter. Load takes effect whatever the state of the two active-low count enables.

Counting needs both enables low. The parallel enable is meant to be shared by every stage of a chain. The trickle enable also gates an active-low terminal-count output. That output goes low at the last value in the present direction: all ones going up, zero going down. It is combinational, so it follows a direction change at once. Wiring each stage's terminal count into the next stage's trickle enable builds a wider synchronous counter with no extra gates.

Top module: `updn_counter`

## Requirements
- R1: With `rst` high at a rising edge, `q` becomes 0 on that edge, whatever the other inputs are.
- R2: With `rst` low and `load_n` low at a rising edge, `q` takes the value of `din`, whatever `ena_p_n` and `ena_t_n` are.
- R3: With `rst` low, `load_n` high, both enables low and `up` high (1 = up), `q` increments by one at the edge.
- R4: Under the same conditions with `up` low (0 = down), `q` decrements by one at the edge.
- R5: Counting wraps modulo 2^WIDTH: all ones goes to 0 counting up, and 0 goes to all ones counting down.
- R6: With `rst` low, `load_n` high and either enable high, `q` keeps its value.
- R7: `tc_n` is low exactly when `ena_t_n` is low and either `up` is high with `q` all ones, or `up` is low with `q` zero. It responds to `up` and `ena_t_n` within the same cycle.
- R8: Three stages chained through `tc_n` into the next `ena_t_n`, with a shared load and parallel enable, count as one 12-bit counter in both directions, including full wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load strobe, active low |
| din | input | WIDTH | Value to load |
| up | input | 1 | Direction: 1 up, 0 down |
| ena_p_n | input | 1 | Parallel count enable, active low |
| ena_t_n | input | 1 | Trickle count enable, active low; also gates `tc_n` |
| q | output | WIDTH | Registered count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
A count result is due at the first rising edge after its stimulus, because one register lies between the inputs and `q`. The driver applies stimulus on the falling edge and queues the expected value. The monitor pops that value and compares it 2 ns after the following rising edge. `tc_n` has no register in its path, so it is checked 1 ns after each stimulus is applied, against the count held before the edge. The chained stages are driven the same way and compared as one 12-bit word after every edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR,
    OP_LOAD,
    OP_INC,
    OP_DEC,
    OP_HOLD
  } updn_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic     rst,
  input  logic     load_n,
  input  logic     up,
  input  logic     ena_p_n,
  input  logic     ena_t_n,
  output updn_op_e op
);
  // priority: reset, then load, then count, else hold
  always_comb begin
    if (rst)                        op = OP_CLEAR;
    else if (!load_n)               op = OP_LOAD;
    else if (!ena_p_n && !ena_t_n)  op = up ? OP_INC : OP_DEC;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  updn_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_INC:   nxt = cur + STEP;
      OP_DEC:   nxt = cur - STEP;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up,
  input  logic             ena_t_n,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] LAST_UP = '1;
  localparam logic [WIDTH-1:0] LAST_DN = '0;

  logic at_end;
  assign at_end = up ? (cur == LAST_UP) : (cur == LAST_DN);
  assign tc_n   = ~(at_end & ~ena_t_n);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up,
  input  logic             ena_p_n,
  input  logic             ena_t_n,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  updn_op_e         op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  updn_ctrl u_ctrl (
    .rst     (rst),
    .load_n  (load_n),
    .up      (up),
    .ena_p_n (ena_p_n),
    .ena_t_n (ena_t_n),
    .op      (op)
  );

  updn_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (cnt_q),
    .din (din),
    .nxt (cnt_d)
  );

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  updn_term #(.WIDTH(WIDTH)) u_term (
    .cur     (cnt_q),
    .up      (up),
    .ena_t_n (ena_t_n),
    .tc_n    (tc_n)
  );

  assign q = cnt_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             up,
  input logic             ena_p_n,
  input logic             ena_t_n,
  input logic [WIDTH-1:0] q,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] FULL = '1;

  logic counting;
  assign counting = load_n && !ena_p_n && !ena_t_n;

  assert_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (q == $past(din)));

  assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (counting && up) |=> (q == $past(q) + ONE));

  assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (counting && !up) |=> (q == $past(q) - ONE));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
    (counting && up && q == FULL) |=> (q == '0));

  assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (rst)
    (counting && !up && q == '0) |=> (q == FULL));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (load_n && (ena_p_n || ena_t_n)) |=> $stable(q));

  assert_tc_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ena_t_n |-> tc_n);

  assert_tc_end_R7: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> (up ? (q == FULL) : (q == '0)));
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_n  (load_n),
  .din     (din),
  .up      (up),
  .ena_p_n (ena_p_n),
  .ena_t_n (ena_t_n),
  .q       (q),
  .tc_n    (tc_n)
);

// File: tb/updn_counter_bench.sv
module updn_counter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // single stage
  logic       rst = 1'b1, load_n = 1'b1, up = 1'b1, ena_p_n = 1'b1, ena_t_n = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       tc_n;

  updn_counter #(.WIDTH(4)) u_updn_counter (
    .clk(clk), .rst(rst), .load_n(load_n), .din(din), .up(up),
    .ena_p_n(ena_p_n), .ena_t_n(ena_t_n), .q(q), .tc_n(tc_n)
  );

  // three-stage chain
  logic        c_rst = 1'b1, c_load_n = 1'b1, c_up = 1'b1, c_en_n = 1'b1;
  logic [11:0] c_din = '0;
  logic [3:0]  cq [3];
  logic        ctc [3];
  logic [11:0] c_word;
  assign c_word = {cq[2], cq[1], cq[0]};

  for (genvar k = 0; k < 3; k++) begin : g_stage
    logic et;
    if (k == 0) begin : g_first
      assign et = c_en_n;
    end else begin : g_rest
      assign et = ctc[k-1];
    end
    updn_counter #(.WIDTH(4)) u_stage (
      .clk(clk), .rst(c_rst), .load_n(c_load_n), .din(c_din[4*k +: 4]),
      .up(c_up), .ena_p_n(c_en_n), .ena_t_n(et), .q(cq[k]), .tc_n(ctc[k])
    );
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [3:0] exp_q [$];
  string      req_q [$];
  logic [3:0] model = '0;
  bit         model_ok = 1'b0;

  task automatic drive(input logic r, input logic l, input logic [3:0] d,
                       input logic u, input logic ep, input logic et, input string req);
    logic [3:0] nxt;
    logic       tc_exp;
    @(negedge clk);
    rst = r; load_n = l; din = d; up = u; ena_p_n = ep; ena_t_n = et;
    #1;
    if (model_ok) begin
      tc_exp = !(!et && (u ? (model == 4'hF) : (model == 4'h0)));
      check(tc_n == tc_exp, "R7", int'(tc_n), int'(tc_exp));
    end
    if (r)                nxt = 4'h0;
    else if (!l)          nxt = d;
    else if (!ep && !et)  nxt = u ? model + 4'h1 : model - 4'h1;
    else                  nxt = model;
    model    = nxt;
    model_ok = 1'b1;
    exp_q.push_back(nxt);
    req_q.push_back(req);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string      rq;
      e  = exp_q.pop_front();
      rq = req_q.pop_front();
      check(q == e, rq, int'(q), int'(e));
    end
  end

  logic [11:0] c_model = '0;

  task automatic cstep(input logic r, input logic l, input logic [11:0] d,
                       input logic u, input logic en, input string req);
    @(negedge clk);
    c_rst = r; c_load_n = l; c_din = d; c_up = u; c_en_n = en;
    if (r)        c_model = '0;
    else if (!l)  c_model = d;
    else if (!en) c_model = u ? c_model + 12'd1 : c_model - 12'd1;
    @(posedge clk);
    #2;
    check(c_word == c_model, req, int'(c_word), int'(c_model));
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // single stage
    drive(1, 1, 4'h0, 1, 1, 1, "R1");
    drive(0, 0, 4'h5, 1, 1, 1, "R2");
    drive(0, 0, 4'h9, 1, 0, 0, "R2");
    drive(0, 1, 4'h0, 1, 0, 0, "R3");
    drive(0, 1, 4'h0, 1, 0, 0, "R3");
    drive(0, 1, 4'h0, 1, 0, 0, "R3");
    drive(0, 1, 4'h0, 1, 1, 0, "R6");
    drive(0, 1, 4'h0, 0, 0, 1, "R6");
    drive(0, 0, 4'hE, 1, 1, 1, "R2");
    drive(0, 1, 4'h0, 1, 0, 0, "R3");
    drive(0, 1, 4'h0, 1, 0, 0, "R5");
    drive(0, 1, 4'h0, 0, 0, 0, "R5");
    drive(0, 1, 4'h0, 0, 0, 0, "R4");
    drive(0, 1, 4'h0, 0, 0, 0, "R4");
    drive(0, 0, 4'hF, 1, 0, 0, "R2");
    drive(0, 1, 4'h0, 0, 1, 0, "R6");
    drive(0, 1, 4'h0, 1, 1, 0, "R6");
    drive(0, 0, 4'h0, 1, 1, 1, "R2");
    drive(0, 1, 4'h0, 0, 1, 0, "R6");
    drive(1, 0, 4'h7, 1, 0, 0, "R1");
    drive(0, 1, 4'h0, 1, 1, 1, "R6");
    repeat (2) @(negedge clk);

    // chain
    cstep(1, 1, 12'h000, 1, 1, "R8");
    cstep(0, 0, 12'h0FE, 1, 1, "R8");
    for (int i = 0; i < 3; i++) cstep(0, 1, 12'h000, 1, 0, "R8");
    cstep(0, 0, 12'h101, 0, 0, "R8");
    for (int i = 0; i < 3; i++) cstep(0, 1, 12'h000, 0, 0, "R8");
    cstep(0, 0, 12'hFFE, 1, 0, "R8");
    for (int i = 0; i < 3; i++) cstep(0, 1, 12'h000, 1, 0, "R8");
    for (int i = 0; i < 2; i++) cstep(0, 1, 12'h000, 0, 0, "R8");
    cstep(0, 1, 12'h000, 1, 1, "R8");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule